// File: doc/BRIEF.md
# Byte alignment address and data unit

This unit carries out two related operations that share a byte-offset field held in a small status register. The address operation adds two 64-bit operands and returns the sum rounded down to an 8-byte boundary. The three low bits of the sum, which are dropped from the result, go into the status register. The data operation treats two 64-bit sources as one 16-byte string, with the first source in front. It returns the 8 bytes that begin at the stored byte offset. A misaligned stream is handled by running the address operation once, then issuing data operations on pairs of neighbouring aligned words.

Requests enter over a valid/ready handshake and carry an operation select and two operands. Results leave over a second valid/ready handshake. A two-state controller governs the handshakes. In state `S_IDLE` the unit accepts a request. The transition `T_ACCEPT` (request valid while ready) loads the result register and, for an address operation, the offset. The controller then moves to `S_RESP`. In `S_RESP` the result is offered and no request is taken. The transition `T_RELEASE` (response taken by the consumer) returns the controller to `S_IDLE`. Because requests are handled strictly one at a time, a data operation always uses the offset left by every address operation accepted before it.

Top module: `byte_align_unit`

## Requirements
- R1: For an address operation (`req_op` = 0), `rsp_data` equals (`req_a` + `req_b`) modulo 2^64 with bits [2:0] forced to zero.
- R2: An accepted address operation sets `align_q` to bits [2:0] of that sum, visible in the cycle after acceptance. A data operation (`req_op` = 1) leaves `align_q` unchanged.
- R3: For a data operation with offset k in 1..7, `rsp_data` equals (`req_a` << 8k) | (`req_b` >> (64 − 8k)).
- R4: For a data operation with offset 0, `rsp_data` equals `req_a` exactly, and `req_b` contributes nothing.
- R5: After reset, `align_q` is 0, `rsp_valid` is 0 and `req_ready` is 1. A data operation issued before any address operation therefore passes `req_a` through unchanged.
- R6: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in the next cycle, and `req_ready` stays 0 while `rsp_valid` is 1.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` stays unchanged.
- R8: A data operation accepted after an address operation uses the offset that address operation wrote.
- R9: `align_q` changes only on the acceptance of an address operation. A request presented while the unit is busy has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 1 | 0 = address alignment, 1 = data alignment |
| req_a | input | 64 | Address operand, or the leading data word |
| req_b | input | 64 | Offset operand, or the trailing data word |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 64 | Result word |
| align_q | output | 3 | Stored byte offset |

## Verification
The address operation is tried with sums that land on each of several offsets. These include a carry that wraps past bit 63 and a sum that rolls exactly onto a boundary, which separates a correct 64-bit add and masking from a truncated or unmasked one. Each address step is followed by a data operation on the same pair of distinctive byte patterns, so every byte of the result shows which source and lane it came from. Offsets 0, 1, 5, 6 and 7 expose errors in byte direction, in the shift amount, and in the suppression of the trailing word at offset zero. Directed runs cover a data operation straight after reset, and a stalled response with a competing request held on the input, which must change neither the held result nor the offset.

// File: rtl/bam_pkg.sv
package bam_pkg;
    localparam int unsigned WORD_W  = 64;
    localparam int unsigned LANES   = WORD_W / 8;
    localparam int unsigned OFF_W   = $clog2(LANES);

    typedef enum logic {
        OP_ADDR = 1'b0,
        OP_DATA = 1'b1
    } op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } state_e;
endpackage

// File: rtl/bam_addr_align.sv
module bam_addr_align #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned OFF_W  = 3
) (
    input  logic [WORD_W-1:0] base_i,
    input  logic [WORD_W-1:0] incr_i,
    output logic [WORD_W-1:0] aligned_o,
    output logic [OFF_W-1:0]  low_o
);
    logic [WORD_W-1:0] sum;

    always_comb begin
        sum       = base_i + incr_i;
        low_o     = sum[OFF_W-1:0];
        aligned_o = {sum[WORD_W-1:OFF_W], {OFF_W{1'b0}}};
    end
endmodule

// File: rtl/bam_funnel.sv
module bam_funnel #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned LANES  = 8,
    parameter int unsigned OFF_W  = 3
) (
    input  logic [WORD_W-1:0] lead_i,
    input  logic [WORD_W-1:0] trail_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [WORD_W-1:0] out_o
);
    logic [WORD_W-1:0] cand [LANES];

    // One fixed-shift candidate per offset; offset 0 takes the lead word alone.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_zero
            assign cand[k] = lead_i;
        end else begin : g_shift
            assign cand[k] = (lead_i << (8 * k)) | (trail_i >> (WORD_W - 8 * k));
        end
    end

    assign out_o = cand[off_i];
endmodule

// File: rtl/bam_align_reg.sv
module bam_align_reg #(
    parameter int unsigned OFF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [OFF_W-1:0] d_i,
    output logic [OFF_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (wr_i) q_o <= d_i;
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(q_o))
        else $error("offset changed without a write");
endmodule

// File: rtl/bam_ctrl.sv
module bam_ctrl
    import bam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid_i,
    input  logic rsp_ready_i,
    output logic req_ready_o,
    output logic rsp_valid_o,
    output logic accept_o
);
    state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        req_ready_o = 1'b0;
        rsp_valid_o = 1'b0;
        accept_o    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready_o = 1'b1;
                if (req_valid_i) begin
                    accept_o = 1'b1;
                    state_d  = S_RESP;
                end
            end
            S_RESP: begin
                rsp_valid_o = 1'b1;
                if (rsp_ready_i) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    p_rsp_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> rsp_valid_o)
        else $error("no response after accept");

    p_busy_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !req_ready_o)
        else $error("ready while response pending");
endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit
    import bam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [WORD_W-1:0] req_a,
    input  logic [WORD_W-1:0] req_b,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_data,
    output logic [OFF_W-1:0]  align_q
);
    logic              accept;
    logic [WORD_W-1:0] addr_res;
    logic [OFF_W-1:0]  addr_low;
    logic [WORD_W-1:0] data_res;
    logic [WORD_W-1:0] res_d;
    logic              op_q;

    bam_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .rsp_ready_i (rsp_ready),
        .req_ready_o (req_ready),
        .rsp_valid_o (rsp_valid),
        .accept_o    (accept)
    );

    bam_addr_align #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_addr (
        .base_i    (req_a),
        .incr_i    (req_b),
        .aligned_o (addr_res),
        .low_o     (addr_low)
    );

    bam_funnel #(.WORD_W(WORD_W), .LANES(LANES), .OFF_W(OFF_W)) u_funnel (
        .lead_i  (req_a),
        .trail_i (req_b),
        .off_i   (align_q),
        .out_o   (data_res)
    );

    bam_align_reg #(.OFF_W(OFF_W)) u_off (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (accept && (op_e'(req_op) == OP_ADDR)),
        .d_i   (addr_low),
        .q_o   (align_q)
    );

    always_comb begin
        res_d = (op_e'(req_op) == OP_ADDR) ? addr_res : data_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data <= '0;
            op_q     <= 1'b0;
        end else if (accept) begin
            rsp_data <= res_d;
            op_q     <= req_op;
        end
    end

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)))
        else $error("response changed while stalled");

    p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q == 1'b0) |-> (rsp_data[OFF_W-1:0] == '0))
        else $error("address result not on a word boundary");
endmodule

// File: tb/byte_align_unit_tb_top.sv
module byte_align_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic [63:0] req_a = '0;
    logic [63:0] req_b = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_data;
    logic [2:0]  align_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    byte_align_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_a(req_a), .req_b(req_b), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data), .align_q(align_q)
    );

    typedef struct packed {
        logic        op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp_data;
        logic [2:0]  exp_off;
    } vec_t;

    localparam logic [63:0] LEAD  = 64'h0011223344556677;
    localparam logic [63:0] TRAIL = 64'h8899AABBCCDDEEFF;
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'h1000, 64'h5, 64'h1000, 3'd5},
        '{1'b1, LEAD, TRAIL, 64'h5566778899AABBCC, 3'd5},
        '{1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h2, 64'h0, 3'd1},
        '{1'b1, LEAD, TRAIL, 64'h1122334455667788, 3'd1},
        '{1'b0, 64'h7, 64'h1, 64'h8, 3'd0},
        '{1'b1, LEAD, TRAIL, LEAD, 3'd0},
        '{1'b0, 64'hF, 64'h0, 64'h8, 3'd7},
        '{1'b1, LEAD, TRAIL, 64'h778899AABBCCDDEE, 3'd7},
        '{1'b0, 64'h123456789ABCDEF3, 64'h3, 64'h123456789ABCDEF0, 3'd6},
        '{1'b1, LEAD, TRAIL, 64'h66778899AABBCCDD, 3'd6}
    };

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Issue one request, take the response at once; returns result and offset.
    task automatic run_op(input logic op, input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] res, output logic [2:0] off,
                          output logic vld);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        vld = rsp_valid; res = rsp_data; off = align_q;
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] res;
        logic [2:0]  off;
        logic        vld;

        repeat (3) @(negedge clk);
        check64("R5 ready in reset-idle", {63'd0, req_ready}, 64'd1);
        check64("R5 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        check64("R5 offset after reset", {61'd0, align_q}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5/R4: data op before any address op passes the lead word through
        run_op(1'b1, LEAD, TRAIL, res, off, vld);
        check64("R6 valid one cycle after accept", {63'd0, vld}, 64'd1);
        check64("R5 data before address op", res, LEAD);
        check64("R5 offset still zero", {61'd0, off}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].a, VECS[i].b, res, off, vld);
            check64(VECS[i].op ? "R3/R4/R8 data result" : "R1 address result",
                    res, VECS[i].exp_data);
            check64(VECS[i].op ? "R2 data op keeps offset" : "R2 offset written",
                    {61'd0, off}, {61'd0, VECS[i].exp_off});
            check64("R6 response valid", {63'd0, vld}, 64'd1);
        end

        // R7/R9: stalled response with a competing address request held at input
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_a = 64'h100; req_b = 64'h3;
        @(posedge clk);
        @(negedge clk);
        req_a = 64'h200; req_b = 64'h1;
        check64("R1 stalled address result", rsp_data, 64'h100);
        check64("R2 offset from stalled op", {61'd0, align_q}, 64'd3);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check64("R7 valid held while stalled", {63'd0, rsp_valid}, 64'd1);
            check64("R7 data held while stalled", rsp_data, 64'h100);
            check64("R6 ready low while busy", {63'd0, req_ready}, 64'd0);
            check64("R9 busy request ignored", {61'd0, align_q}, 64'd3);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; rsp_ready = 1'b0;
        check64("R6 released to idle", {63'd0, rsp_valid}, 64'd0);
        check64("R9 offset after stall", {61'd0, align_q}, 64'd3);

        // R8: data op right after the stalled address op uses offset 3
        run_op(1'b1, LEAD, TRAIL, res, off, vld);
        check64("R8 data uses latest offset", res, 64'h33445566778899AA);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule